// File: doc/BRIEF.md
# Home-Node Full-Map Coherence Directory

This block sits at the home node of a shared-memory system and keeps, for every memory line, a stable or transient coherence state and a full vector with one presence bit per node. Nodes send it read, read-for-ownership and upgrade requests. It answers with a data reply, a set of invalidations, a forward to the current owner, or a negative acknowledgement that tells the requester to retry. A second input carries invalidation acknowledgements and owner-completion notices. A separate completion output issues the ownership grant once the last acknowledgement has arrived.

A parameter selects the four-state protocol or the three-state protocol. In the four-state protocol a read to an uncached line is granted exclusively. A line held Exclusive or Modified is never served from memory. The request goes to the owner, and the owner ships the data straight to the requester. The directory entry and the line's memory word are both captured in the cycle a request is accepted. The reply leaves a fixed number of cycles later, set by the slower of the directory and memory latencies plus a packet-build latency.

Memory is modelled as a fixed-latency stub whose words reset to a computed pattern. It takes the owner's data when a forwarded read completes.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is uncached with an empty presence vector, `req_ready` is 1, `rsp_valid` and `cmp_valid` are 0, and memory word of line a holds (a*37+5) truncated to DW bits.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the reply. The reply is a one-cycle `rsp_valid` pulse registered LAT = max(DIR_LAT, MEM_LAT) + PKT_LAT edges after the accepting edge. DIR_LAT must be at least 1.
- R3: A read (req_type 0) to an uncached line replies with DATA_E (rsp_type 1) and the line becomes Exclusive when MESI=1. When MESI=0 it replies with DATA_S (rsp_type 0) and the line becomes Shared. The reply carries the memory word and sets the requester as the only presence bit.
- R4: A read to a Shared line replies with DATA_S and the memory word, and adds the requester to the presence vector.
- R5: A read to an Exclusive or Modified line sends FWD_RD (rsp_type 5) to the owner's presence bit, with `rsp_src` set to the requester. An owner notice (resp_kind 1) then writes `resp_data` into memory and makes the line Shared by owner and requester.
- R6: A read-for-ownership (req_type 1) to a Shared line with other sharers sends INV (rsp_type 4) to the mask of all sharers except the requester. An upgrade (req_type 2) does the same. An upgrade from a node not in the presence vector behaves as a read-for-ownership.
- R7: When no other node holds the line, a read-for-ownership gets DATA_M (rsp_type 2) with the memory word at once, and an upgrade from the sole sharer gets GRANT (rsp_type 3) with zero data. The line becomes Modified, held by the requester only.
- R8: A read-for-ownership to an Exclusive or Modified line sends FWD_WR (rsp_type 6) to the owner. The owner notice then makes the line Modified, held by the requester only, and leaves memory unchanged.
- R9: Any request to a line in a transient state, and any request with req_type 3, is answered with NACK (rsp_type 7) to the requester and changes no state.
- R10: An acknowledgement (resp_kind 0) or owner notice for a line that is not waiting for it changes no state and produces no output.
- R11: Each invalidating line counts outstanding acknowledgements. The completion port issues nothing until the count reaches zero. The ack that empties the count produces, one edge later, a single `cmp_valid` pulse: DATA_M with the current memory word for a read-for-ownership, or GRANT with zero data for an upgrade. The pulse goes to the waiting requester, and the line becomes Modified, held by it alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_type | input | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 reserved |
| req_node | input | NW | Requesting node |
| req_line | input | LW | Line index |
| resp_valid | input | 1 | Acknowledgement or owner notice present |
| resp_kind | input | 1 | 0 invalidation ack, 1 owner notice |
| resp_line | input | LW | Line the notice refers to |
| resp_data | input | DW | Owner data for a forwarded read |
| rsp_valid | output | 1 | Reply message valid |
| rsp_type | output | 3 | Reply message code |
| rsp_dst | output | NODES | Destination mask, bit i is node i |
| rsp_src | output | NW | Original requester |
| rsp_line | output | LW | Line of the reply |
| rsp_data | output | DW | Memory word for data replies, else 0 |
| cmp_valid | output | 1 | Ownership grant valid |
| cmp_type | output | 3 | 2 DATA_M or 3 GRANT |
| cmp_dst | output | NODES | Requester mask |
| cmp_line | output | LW | Line granted |
| cmp_data | output | DW | Memory word for DATA_M, else 0 |

## Verification
A wrong presence vector surfaces at the next request to the line: the invalidation mask or the forward target comes out one LAT window after acceptance. A wrong state shows as a data reply where a forward or NACK was due, or the reverse. A corrupted acknowledgement count appears as a grant one edge too early or never. A missed memory writeback appears in the data word of the next reply for that line. Two instances, one per protocol, are driven with the same stimulus. The differences between their states and acknowledgement counts are therefore also exercised on every clock.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_READX = 2'd1, RQ_UPG = 2'd2, RQ_RSVD = 2'd3} req_e;

  typedef enum logic [2:0] {
    M_DATA_S = 3'd0, M_DATA_E = 3'd1, M_DATA_M = 3'd2, M_GRANT = 3'd3,
    M_INV = 3'd4, M_FWD_RD = 3'd5, M_FWD_WR = 3'd6, M_NACK = 3'd7
  } msg_e;

  typedef enum logic [2:0] {
    L_I = 3'd0, L_S = 3'd1, L_E = 3'd2, L_M = 3'd3,
    L_WINV_X = 3'd4, L_WINV_U = 3'd5, L_WOWN_RD = 3'd6, L_WOWN_WR = 3'd7
  } lst_e;

  localparam logic RS_ACK = 1'b0;
  localparam logic RS_OWNER = 1'b1;
endpackage

// File: rtl/coh_mem_stub.sv
module coh_mem_stub #(
  parameter int LINES = 16,
  parameter int DW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [LW-1:0] rd_line,
  output logic [DW-1:0] rd_data,
  input  logic [LW-1:0] pk_line,
  output logic [DW-1:0] pk_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] mem_q [LINES];

  assign pk_data = mem_q[pk_line];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= DW'(32'(i) * 32'd37 + 32'd5);
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= mem_q[rd_line];
      if (wr_en) mem_q[wr_line] <= wr_data;
    end
  end
endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 16,
  parameter int NW = 2,
  parameter int LW = 4,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    a_line,
  output lst_e             a_state,
  output logic [NODES-1:0] a_pres,
  input  logic [LW-1:0]    b_line,
  output lst_e             b_state,
  output logic [NODES-1:0] b_pres,
  output logic [NW-1:0]    b_pend,
  output logic [AW-1:0]    b_acks,
  input  logic             wa_en,
  input  logic [LW-1:0]    wa_line,
  input  lst_e             wa_state,
  input  logic [NODES-1:0] wa_pres,
  input  logic [NW-1:0]    wa_pend,
  input  logic [AW-1:0]    wa_acks,
  input  logic             wb_en,
  input  logic [LW-1:0]    wb_line,
  input  lst_e             wb_state,
  input  logic [NODES-1:0] wb_pres,
  input  logic [NW-1:0]    wb_pend,
  input  logic [AW-1:0]    wb_acks
);
  lst_e             st_q [LINES];
  logic [NODES-1:0] pr_q [LINES];
  logic [NW-1:0]    pd_q [LINES];
  logic [AW-1:0]    ak_q [LINES];

  assign a_state = st_q[a_line];
  assign a_pres  = pr_q[a_line];
  assign b_state = st_q[b_line];
  assign b_pres  = pr_q[b_line];
  assign b_pend  = pd_q[b_line];
  assign b_acks  = ak_q[b_line];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i] <= L_I;
        pr_q[i] <= '0;
        pd_q[i] <= '0;
        ak_q[i] <= '0;
      end
    end else begin
      if (wa_en) begin
        st_q[wa_line] <= wa_state;
        pr_q[wa_line] <= wa_pres;
        pd_q[wa_line] <= wa_pend;
        ak_q[wa_line] <= wa_acks;
      end
      if (wb_en) begin
        st_q[wb_line] <= wb_state;
        pr_q[wb_line] <= wb_pres;
        pd_q[wb_line] <= wb_pend;
        ak_q[wb_line] <= wb_acks;
      end
    end
  end
endmodule

// File: rtl/coh_dir_policy.sv
module coh_dir_policy
  import coh_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NW = 2,
  parameter int AW = 3,
  parameter bit MESI = 1'b1
) (
  input  req_e             rq_type,
  input  logic [NW-1:0]    rq_node,
  input  lst_e             st,
  input  logic [NODES-1:0] pres,
  output msg_e             o_type,
  output logic [NODES-1:0] o_dst,
  output logic             o_data,
  output logic             wr_en,
  output lst_e             n_state,
  output logic [NODES-1:0] n_pres,
  output logic [AW-1:0]    n_acks
);
  logic [NODES-1:0] rb, others;
  logic holder, transient;

  function automatic logic [AW-1:0] popcnt(input logic [NODES-1:0] v);
    logic [AW-1:0] c;
    c = '0;
    for (int i = 0; i < NODES; i++) c = c + AW'(v[i]);
    return c;
  endfunction

  assign rb        = NODES'(1) << rq_node;
  assign others    = pres & ~rb;
  assign holder    = |(pres & rb);
  assign transient = st[2];

  always_comb begin
    o_type  = M_NACK;
    o_dst   = rb;
    o_data  = 1'b0;
    wr_en   = 1'b0;
    n_state = st;
    n_pres  = pres;
    n_acks  = '0;
    if (rq_type == RQ_RSVD || transient) begin
      o_type = M_NACK;
    end else if (rq_type == RQ_READ) begin
      wr_en = 1'b1;
      if (st == L_I) begin
        o_type  = MESI ? M_DATA_E : M_DATA_S;
        n_state = MESI ? L_E : L_S;
        n_pres  = rb;
        o_data  = 1'b1;
      end else if (st == L_S) begin
        o_type = M_DATA_S;
        n_pres = pres | rb;
        o_data = 1'b1;
      end else begin
        o_type  = M_FWD_RD;
        o_dst   = pres;
        n_state = L_WOWN_RD;
      end
    end else begin
      wr_en = 1'b1;
      if (st == L_I || (st == L_S && others == '0)) begin
        o_type  = (rq_type == RQ_UPG && holder) ? M_GRANT : M_DATA_M;
        o_data  = !(rq_type == RQ_UPG && holder);
        n_state = L_M;
        n_pres  = rb;
      end else if (st == L_S) begin
        o_type  = M_INV;
        o_dst   = others;
        n_state = (rq_type == RQ_UPG && holder) ? L_WINV_U : L_WINV_X;
        n_acks  = popcnt(others);
      end else begin
        o_type  = M_FWD_WR;
        o_dst   = pres;
        n_state = L_WOWN_WR;
      end
    end
  end
endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
  import coh_dir_pkg::*;
#(
  parameter int NODES = 4,
  parameter int LINES = 16,
  parameter int DW = 16,
  parameter bit MESI = 1'b1,
  parameter int DIR_LAT = 2,
  parameter int MEM_LAT = 3,
  parameter int PKT_LAT = 1,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [NW-1:0]    req_node,
  input  logic [LW-1:0]    req_line,
  input  logic             resp_valid,
  input  logic             resp_kind,
  input  logic [LW-1:0]    resp_line,
  input  logic [DW-1:0]    resp_data,
  output logic             rsp_valid,
  output logic [2:0]       rsp_type,
  output logic [NODES-1:0] rsp_dst,
  output logic [NW-1:0]    rsp_src,
  output logic [LW-1:0]    rsp_line,
  output logic [DW-1:0]    rsp_data,
  output logic             cmp_valid,
  output logic [2:0]       cmp_type,
  output logic [NODES-1:0] cmp_dst,
  output logic [LW-1:0]    cmp_line,
  output logic [DW-1:0]    cmp_data
);
  localparam int AW  = $clog2(NODES + 1);
  localparam int LAT = ((DIR_LAT > MEM_LAT) ? DIR_LAT : MEM_LAT) + PKT_LAT;
  localparam int CW  = $clog2(LAT + 1);

  logic             busy;
  logic [CW-1:0]    cnt;
  req_e             s_type;
  logic [NW-1:0]    s_node;
  logic [LW-1:0]    s_line;
  lst_e             s_state;
  logic [NODES-1:0] s_pres;
  logic             accept, decide;

  lst_e             a_state, b_state;
  logic [NODES-1:0] a_pres, b_pres;
  logic [NW-1:0]    b_pend;
  logic [AW-1:0]    b_acks;

  msg_e             p_type;
  logic [NODES-1:0] p_dst, p_pres;
  logic             p_data, p_wr;
  lst_e             p_state;
  logic [AW-1:0]    p_acks;

  logic [DW-1:0]    mem_rd, mem_pk;
  logic             rs_ack, rs_last, rs_own, wb_en, mem_wr;
  lst_e             wb_state;
  logic [NODES-1:0] wb_pres, pend_mask;
  logic [AW-1:0]    wb_acks;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign decide    = busy && (cnt == '0);

  // Snapshot of the directory entry taken together with the memory read
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      s_type  <= RQ_READ;
      s_node  <= '0;
      s_line  <= '0;
      s_state <= L_I;
      s_pres  <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      cnt     <= CW'(LAT - 1);
      s_type  <= req_e'(req_type);
      s_node  <= req_node;
      s_line  <= req_line;
      s_state <= a_state;
      s_pres  <= a_pres;
    end else if (decide) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  coh_mem_stub #(.LINES(LINES), .DW(DW), .LW(LW)) u_mem (
    .clk(clk), .rst(rst), .rd_en(accept), .rd_line(req_line), .rd_data(mem_rd),
    .pk_line(resp_line), .pk_data(mem_pk),
    .wr_en(mem_wr), .wr_line(resp_line), .wr_data(resp_data)
  );

  coh_dir_policy #(.NODES(NODES), .NW(NW), .AW(AW), .MESI(MESI)) u_pol (
    .rq_type(s_type), .rq_node(s_node), .st(s_state), .pres(s_pres),
    .o_type(p_type), .o_dst(p_dst), .o_data(p_data), .wr_en(p_wr),
    .n_state(p_state), .n_pres(p_pres), .n_acks(p_acks)
  );

  // Acknowledgement and owner-notice path
  assign pend_mask = NODES'(1) << b_pend;
  assign rs_ack  = resp_valid && resp_kind == RS_ACK && (b_state == L_WINV_X || b_state == L_WINV_U);
  assign rs_last = rs_ack && b_acks == AW'(1);
  assign rs_own  = resp_valid && resp_kind == RS_OWNER && (b_state == L_WOWN_RD || b_state == L_WOWN_WR);
  assign wb_en   = rs_ack || rs_own;
  assign mem_wr  = rs_own && b_state == L_WOWN_RD;

  always_comb begin
    wb_state = b_state;
    wb_pres  = b_pres;
    wb_acks  = '0;
    if (rs_ack) begin
      wb_acks = b_acks - AW'(1);
      if (rs_last) begin
        wb_state = L_M;
        wb_pres  = pend_mask;
      end
    end else if (rs_own) begin
      wb_state = (b_state == L_WOWN_RD) ? L_S : L_M;
      wb_pres  = (b_state == L_WOWN_RD) ? (b_pres | pend_mask) : pend_mask;
    end
  end

  coh_dir_store #(.NODES(NODES), .LINES(LINES), .NW(NW), .LW(LW), .AW(AW)) u_store (
    .clk(clk), .rst(rst),
    .a_line(req_line), .a_state(a_state), .a_pres(a_pres),
    .b_line(resp_line), .b_state(b_state), .b_pres(b_pres), .b_pend(b_pend), .b_acks(b_acks),
    .wa_en(decide && p_wr), .wa_line(s_line), .wa_state(p_state), .wa_pres(p_pres),
    .wa_pend(s_node), .wa_acks(p_acks),
    .wb_en(wb_en), .wb_line(resp_line), .wb_state(wb_state), .wb_pres(wb_pres),
    .wb_pend(b_pend), .wb_acks(wb_acks)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_type  <= '0;
      rsp_dst   <= '0;
      rsp_src   <= '0;
      rsp_line  <= '0;
      rsp_data  <= '0;
      cmp_valid <= 1'b0;
      cmp_type  <= '0;
      cmp_dst   <= '0;
      cmp_line  <= '0;
      cmp_data  <= '0;
    end else begin
      rsp_valid <= decide;
      if (decide) begin
        rsp_type <= p_type;
        rsp_dst  <= p_dst;
        rsp_src  <= s_node;
        rsp_line <= s_line;
        rsp_data <= p_data ? mem_rd : '0;
      end
      cmp_valid <= rs_last;
      if (rs_last) begin
        cmp_type <= (b_state == L_WINV_X) ? M_DATA_M : M_GRANT;
        cmp_dst  <= pend_mask;
        cmp_line <= resp_line;
        cmp_data <= (b_state == L_WINV_X) ? mem_pk : '0;
      end
    end
  end
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int NODES = 4,
  parameter bit MESI = 1'b1,
  parameter int LAT = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_type,
  input logic [NODES-1:0] rsp_dst,
  input logic             cmp_valid,
  input logic [2:0]       cmp_type,
  input logic [NODES-1:0] cmp_dst
);
  int since;

  always_ff @(posedge clk) begin
    if (rst) since <= 0;
    else if (req_valid && req_ready) since <= 1;
    else if (since != 0 && since < LAT + 2) since <= since + 1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> since == LAT + 1);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_msi_no_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !MESI) |-> rsp_type != 3'd1);
  assert_single_target_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type != 3'd4) |-> $countones(rsp_dst) == 1);
  assert_inv_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 3'd4) |-> rsp_dst != '0);
  assert_grant_shape_R11: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |-> ($countones(cmp_dst) == 1 && (cmp_type == 3'd2 || cmp_type == 3'd3)));
endmodule

bind coh_home_dir coh_home_dir_chk #(.NODES(NODES), .MESI(MESI), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dst(rsp_dst),
  .cmp_valid(cmp_valid), .cmp_type(cmp_type), .cmp_dst(cmp_dst)
);

// File: tb/sim_coh_home_dir.sv
module sim_coh_home_dir;
  localparam int NODES = 4, LINES = 16, DW = 16, NW = 2, LW = 4;
  localparam int LAT = 4;  // max(2,3)+1

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, resp_valid = 1'b0, resp_kind = 1'b0;
  logic [1:0] req_type = '0;
  logic [NW-1:0] req_node = '0;
  logic [LW-1:0] req_line = '0, resp_line = '0;
  logic [DW-1:0] resp_data = '0;

  logic [1:0] d_rdy, d_rv, d_cv;
  logic [2:0] d_rt [2], d_ct [2];
  logic [NODES-1:0] d_rd [2], d_cd [2];
  logic [NW-1:0] d_rs [2];
  logic [LW-1:0] d_rl [2], d_cl [2];
  logic [DW-1:0] d_rdat [2], d_cdat [2];

  coh_home_dir #(.MESI(1'b1)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(d_rdy[0]), .req_type(req_type),
    .req_node(req_node), .req_line(req_line), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_line(resp_line), .resp_data(resp_data), .rsp_valid(d_rv[0]), .rsp_type(d_rt[0]),
    .rsp_dst(d_rd[0]), .rsp_src(d_rs[0]), .rsp_line(d_rl[0]), .rsp_data(d_rdat[0]),
    .cmp_valid(d_cv[0]), .cmp_type(d_ct[0]), .cmp_dst(d_cd[0]), .cmp_line(d_cl[0]), .cmp_data(d_cdat[0]));

  coh_home_dir #(.MESI(1'b0)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(d_rdy[1]), .req_type(req_type),
    .req_node(req_node), .req_line(req_line), .resp_valid(resp_valid), .resp_kind(resp_kind),
    .resp_line(resp_line), .resp_data(resp_data), .rsp_valid(d_rv[1]), .rsp_type(d_rt[1]),
    .rsp_dst(d_rd[1]), .rsp_src(d_rs[1]), .rsp_line(d_rl[1]), .rsp_data(d_rdat[1]),
    .cmp_valid(d_cv[1]), .cmp_type(d_ct[1]), .cmp_dst(d_cd[1]), .cmp_line(d_cl[1]), .cmp_data(d_cdat[1]));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // Reference model: states 0 I,1 S,2 E,3 M,4 wait-inv-x,5 wait-inv-u,6 wait-own-rd,7 wait-own-wr
  int mst [2][LINES], mpr [2][LINES], mpd [2][LINES], mak [2][LINES], mmem [2][LINES];
  int sn_st [2], sn_pr [2], sn_d [2];
  int sn_type, sn_node, sn_line, mcnt;
  bit mbusy = 0, m_acc = 0;
  bit e_rv [2], e_cv [2];
  int e_rt [2], e_rd [2], e_rs [2], e_rl [2], e_rdat [2], e_ct [2], e_cd [2], e_cl [2], e_cdat [2];

  function automatic int minit(int a);
    return (a * 37 + 5) & ((1 << DW) - 1);
  endfunction

  function automatic int pc(int v);
    int c = 0;
    for (int i = 0; i < NODES; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic decide(int m);
    int rb, oth, st, pr;
    bit hold, upg;
    rb = 1 << sn_node; st = sn_st[m]; pr = sn_pr[m];
    oth = pr & ~rb; hold = (pr & rb) != 0; upg = (sn_type == 2);
    e_rv[m] = 1; e_rs[m] = sn_node; e_rl[m] = sn_line; e_rdat[m] = 0; e_rd[m] = rb;
    if (sn_type == 3 || st >= 4) e_rt[m] = 7;
    else begin
      mpd[m][sn_line] = sn_node; mak[m][sn_line] = 0;
      if (sn_type == 0) begin
        if (st == 0) begin
          e_rt[m] = (m == 0) ? 1 : 0; mst[m][sn_line] = (m == 0) ? 2 : 1;
          mpr[m][sn_line] = rb; e_rdat[m] = sn_d[m];
        end else if (st == 1) begin
          e_rt[m] = 0; mpr[m][sn_line] = pr | rb; e_rdat[m] = sn_d[m];
        end else begin
          e_rt[m] = 5; e_rd[m] = pr; mst[m][sn_line] = 6;
        end
      end else if (st == 0 || (st == 1 && oth == 0)) begin
        e_rt[m] = (upg && hold) ? 3 : 2; e_rdat[m] = (upg && hold) ? 0 : sn_d[m];
        mst[m][sn_line] = 3; mpr[m][sn_line] = rb;
      end else if (st == 1) begin
        e_rt[m] = 4; e_rd[m] = oth; mst[m][sn_line] = (upg && hold) ? 5 : 4;
        mak[m][sn_line] = pc(oth);
      end else begin
        e_rt[m] = 6; e_rd[m] = pr; mst[m][sn_line] = 7;
      end
    end
  endtask

  task automatic apply_resp(int m);
    int l, st;
    l = resp_line; st = mst[m][l];
    if (resp_kind == 0 && (st == 4 || st == 5)) begin
      mak[m][l]--;
      if (mak[m][l] == 0) begin
        e_cv[m] = 1; e_ct[m] = (st == 4) ? 2 : 3; e_cd[m] = 1 << mpd[m][l]; e_cl[m] = l;
        e_cdat[m] = (st == 4) ? mmem[m][l] : 0;
        mst[m][l] = 3; mpr[m][l] = 1 << mpd[m][l];
      end
    end else if (resp_kind == 1 && st == 6) begin
      mmem[m][l] = resp_data; mst[m][l] = 1; mpr[m][l] |= 1 << mpd[m][l];
    end else if (resp_kind == 1 && st == 7) begin
      mst[m][l] = 3; mpr[m][l] = 1 << mpd[m][l];
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    m_acc = 0;
    if (rst) begin
      mbusy = 0; mcnt = 0;
      for (int m = 0; m < 2; m++) begin
        e_rv[m] = 0; e_cv[m] = 0;
        for (int i = 0; i < LINES; i++) begin
          mst[m][i] = 0; mpr[m][i] = 0; mpd[m][i] = 0; mak[m][i] = 0; mmem[m][i] = minit(i);
        end
      end
    end else begin
      for (int m = 0; m < 2; m++) begin e_rv[m] = 0; e_cv[m] = 0; end
      if (mbusy) begin
        if (mcnt == 0) begin
          for (int m = 0; m < 2; m++) decide(m);
          mbusy = 0;
        end else mcnt--;
      end else if (req_valid) begin
        sn_type = req_type; sn_node = req_node; sn_line = req_line;
        for (int m = 0; m < 2; m++) begin
          sn_st[m] = mst[m][req_line]; sn_pr[m] = mpr[m][req_line]; sn_d[m] = mmem[m][req_line];
        end
        mbusy = 1; mcnt = LAT - 1; m_acc = 1;
      end
      if (resp_valid) for (int m = 0; m < 2; m++) apply_resp(m);
    end
  end

  function automatic string rtag(int t);
    case (t)
      0: return "R4";
      1: return "R3";
      2, 3: return "R7";
      4: return "R6";
      5: return "R5";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int m = 0; m < 2; m++) begin
        checks++;
        if (d_rdy[m] !== !mbusy) begin
          errors++;
          $display("FAIL R2 u%0d cyc %0d: req_ready actual=%0b expected=%0b", m, cyc, d_rdy[m], !mbusy);
        end
        checks++;
        if (d_rv[m] !== e_rv[m] || (e_rv[m] && (d_rt[m] != 3'(e_rt[m]) || d_rd[m] != NODES'(e_rd[m]) ||
            d_rs[m] != NW'(e_rs[m]) || d_rl[m] != LW'(e_rl[m]) || d_rdat[m] != DW'(e_rdat[m])))) begin
          errors++;
          $display("FAIL %s u%0d cyc %0d: rsp actual v=%0b t=%0d dst=%b src=%0d line=%0d data=%h expected v=%0b t=%0d dst=%b src=%0d line=%0d data=%h",
            e_rv[m] ? rtag(e_rt[m]) : "R2", m, cyc, d_rv[m], d_rt[m], d_rd[m], d_rs[m], d_rl[m], d_rdat[m],
            e_rv[m], e_rt[m], NODES'(e_rd[m]), e_rs[m], e_rl[m], DW'(e_rdat[m]));
        end
        checks++;
        if (d_cv[m] !== e_cv[m] || (e_cv[m] && (d_ct[m] != 3'(e_ct[m]) || d_cd[m] != NODES'(e_cd[m]) ||
            d_cl[m] != LW'(e_cl[m]) || d_cdat[m] != DW'(e_cdat[m])))) begin
          errors++;
          $display("FAIL R11 u%0d cyc %0d: cmp actual v=%0b t=%0d dst=%b line=%0d data=%h expected v=%0b t=%0d dst=%b line=%0d data=%h",
            m, cyc, d_cv[m], d_ct[m], d_cd[m], d_cl[m], d_cdat[m],
            e_cv[m], e_ct[m], NODES'(e_cd[m]), e_cl[m], DW'(e_cdat[m]));
        end
      end
    end
  end

  task automatic req(int t, int n, int l);
    @(negedge clk);
    req_valid = 1; req_type = 2'(t); req_node = NW'(n); req_line = LW'(l);
    do begin @(posedge clk); #1; end while (!m_acc);
    @(negedge clk) req_valid = 0;
  endtask

  task automatic idle();
    while (mbusy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic resp(int k, int l, int d);
    @(negedge clk);
    resp_valid = 1; resp_kind = k[0]; resp_line = LW'(l); resp_data = DW'(d);
    @(negedge clk) resp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset values at the ports
    for (int m = 0; m < 2; m++) begin
      checks++;
      if (d_rdy[m] !== 1'b1 || d_rv[m] !== 1'b0 || d_cv[m] !== 1'b0) begin
        errors++;
        $display("FAIL R1 u%0d: rdy/rv/cv actual=%0b%0b%0b expected=100", m, d_rdy[m], d_rv[m], d_cv[m]);
      end
    end
    // R3 uncached read; R5 forward (MESI) vs R4 shared read (MSI)
    req(0, 0, 1); idle();
    req(0, 1, 1); idle();
    req(0, 2, 1); idle();              // R9 NACK on transient line in MESI
    resp(1, 1, 'hBEEF);                // R5 owner notice, R10 ignored in MSI
    req(1, 3, 1); idle();              // R6 invalidations, counts differ per protocol
    resp(0, 1, 0); resp(0, 1, 0);
    resp(0, 1, 0);                     // R10: extra ack for MESI instance
    checks++;
    if (d_cv[0] !== 1'b0) begin
      errors++;
      $display("FAIL R10 u0: cmp_valid actual=%0b expected=0 after surplus ack", d_cv[0]);
    end
    req(0, 0, 1); idle();              // R5 forward to modified owner
    resp(1, 1, 'h1234);
    req(0, 1, 1); idle();              // R5 memory written by owner notice
    // Upgrade flow on line 2
    req(0, 0, 2); idle();
    req(0, 1, 2); idle();
    resp(1, 2, 'h0A0A);
    req(2, 1, 2); idle();              // R6 upgrade invalidates node 0
    resp(0, 2, 0);                     // R11 grant on last ack
    req(1, 2, 2); idle();              // R8 forward for ownership
    resp(1, 2, 0);
    req(0, 3, 2); idle();
    resp(1, 2, 'h5555);
    req(1, 0, 3); idle();              // R7 uncached read-for-ownership
    req(2, 1, 4); idle();              // R6 upgrade without copy acts as read-for-ownership
    req(3, 2, 5); idle();              // R9 reserved type
    req(0, 0, 6); req(0, 1, 7); idle(); // R2 back-to-back, second held while busy
    req(0, 0, 8); idle();
    req(2, 0, 8); idle();              // R7 sole-sharer upgrade in MSI
    resp(1, 8, 'h7777);
    req(0, 3, 8); idle();
    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule